// File: doc/BRIEF.md
# Serial Control Word Receiver

This block takes control words from a host over a three-wire serial link (data, clock and an active-low enable) and turns them into the settings of an audio control path. The three serial lines are oversampled by a fast system clock. Each line passes through a two-flop synchronizer, and edges are found in the system-clock domain. The system clock must run at least eight times faster than the serial clock.

A frame opens when enable goes low. The first two bits are a device address. When the address matches, any number of further bits may follow. When enable returns high, the nine bits shifted in most recently are taken as a 3-bit function code and a 6-bit value. The value is then written into one of eight setting registers: four faders, volume, treble, bass and input select. The block outputs the stored settings. It also outputs saturated attenuation step counts (2 dB per step) for the volume and the four faders, and a flag that marks an input-select code for the disconnected input.

Top module: `ser_ctrl_rx`

## Requirements
- R1: After reset, volume and all four faders hold 0 and their step counts are 0. Treble and bass hold the flat code 000110. Input select holds 000000 and input_open_o is 1.
- R2: The two bits after the enable falling edge must be 1 then 0. With any other address, no setting changes for that frame.
- R3: A frame may hold any number of bits after a matching address. The nine bits shifted in last are used: the function code first (MSB first), then the value (MSB first).
- R4: A setting changes only on an enable rising edge that ends a valid frame. While the frame is still open, the outputs keep their old values.
- R5: An enable falling edge clears a matched address. If serial clock is high at that falling edge, the frame is void and commits nothing.
- R6: Function codes select the register: 111 left rear fader, 110 right rear fader, 101 left front fader, 100 right front fader, 011 volume, 010 treble, 001 bass, 000 input select. Fader i occupies fader_val_o[6i+5:6i] and fader_step_o[5i+4:5i], where i is the low two bits of its code.
- R7: vol_step_o equals the volume value when that value is 40 or less. It saturates at 40 (the 0 dB step) when the value is above 40.
- R8: A fader step count ignores value bit 5. It equals value bits 4:0 when these are 20 or less, and saturates at 20 otherwise.
- R9: Serial clock edges and data while enable is high have no effect on any output.
- R10: A frame with fewer than nine bits after the address commits nothing.
- R11: input_open_o is 1 when the low four bits of input select are 0000, 0110 or 0111, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial clock, data taken on its rising edge |
| sen_ni | input | 1 | Serial enable, active low |
| fader_val_o | output | 24 | Four stored fader values, 6 bits each |
| volume_o | output | 6 | Stored volume value |
| treble_o | output | 6 | Stored treble value |
| bass_o | output | 6 | Stored bass value |
| input_sel_o | output | 6 | Stored input-select value |
| input_open_o | output | 1 | Selected input is the disconnected one |
| vol_step_o | output | 6 | Saturated volume step count, 0..40 |
| fader_step_o | output | 20 | Saturated fader step counts, 5 bits each, 0..20 |

## Verification
The hardest case to reach is an enable that rises and falls again in the middle of a frame. If the falling edge failed to clear the matched address, the later bits would still commit, and the outputs would look normal. The stimulus sends a partial valid frame, pulses enable high for a few system cycles, and then continues with a deliberately wrong address and a full payload. A correct design ignores that payload, so any change to a setting exposes the fault. Enable falling while serial clock is high is forced the same way: serial clock is held high, enable drops, and a frame that is otherwise valid follows.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;
  localparam int VAL_W     = 6;
  localparam int FUNC_W    = 3;
  localparam int ADDR_W    = 2;
  localparam int PAY_W     = FUNC_W + VAL_W;
  localparam int N_FADER   = 4;
  localparam int VOL_MAX   = 40;
  localparam int FADER_MAX = 20;
  localparam int VSTEP_W   = $clog2(VOL_MAX + 1);
  localparam int FSTEP_W   = $clog2(FADER_MAX + 1);
  localparam logic [VAL_W-1:0]  TONE_FLAT = 6'b000110;
  localparam logic [ADDR_W-1:0] DEV_ADDR  = 2'b10;

  typedef enum logic [FUNC_W-1:0] {
    FN_INSEL  = 3'b000,
    FN_BASS   = 3'b001,
    FN_TREBLE = 3'b010,
    FN_VOLUME = 3'b011
  } func_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/ser_frame_rx.sv
module ser_frame_rx
  import ser_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dat_i,
  input  logic              sclk_i,
  input  logic              en_ni,
  output logic              commit_o,
  output logic              addr_ok_o,
  output logic              en_fall_o,
  output logic [FUNC_W-1:0] func_o,
  output logic [VAL_W-1:0]  val_o
);
  localparam int CNT_W = $clog2(PAY_W + 1);

  logic en_q, clk_q;
  logic en_fall, en_rise, sclk_rise;
  logic [1:0]       hdr_cnt;
  logic             first_bit;
  logic             addr_ok;
  logic             bad;
  logic [CNT_W-1:0] pay_cnt;
  logic [PAY_W-1:0] shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b1;
      clk_q <= 1'b0;
    end else begin
      en_q  <= en_ni;
      clk_q <= sclk_i;
    end
  end

  assign en_fall   = en_q & ~en_ni;
  assign en_rise   = ~en_q & en_ni;
  assign sclk_rise = ~clk_q & sclk_i & ~en_ni & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_cnt   <= '0;
      first_bit <= 1'b0;
      addr_ok   <= 1'b0;
      bad       <= 1'b0;
      pay_cnt   <= '0;
      shreg     <= '0;
    end else if (en_fall) begin
      hdr_cnt <= '0;
      addr_ok <= 1'b0;
      bad     <= sclk_i;  // enable must fall while serial clock is low
      pay_cnt <= '0;
    end else if (sclk_rise) begin
      if (hdr_cnt == 2'd0) begin
        first_bit <= dat_i;
        hdr_cnt   <= 2'd1;
      end else if (hdr_cnt == 2'd1) begin
        addr_ok <= ({first_bit, dat_i} == DEV_ADDR);
        hdr_cnt <= 2'd2;
      end else begin
        shreg <= {shreg[PAY_W-2:0], dat_i};
        if (pay_cnt != CNT_W'(PAY_W)) pay_cnt <= pay_cnt + 1'b1;
      end
    end
  end

  assign commit_o  = en_rise & addr_ok & ~bad & (pay_cnt == CNT_W'(PAY_W));
  assign addr_ok_o = addr_ok;
  assign en_fall_o = en_fall;
  assign func_o    = shreg[PAY_W-1:VAL_W];
  assign val_o     = shreg[VAL_W-1:0];
endmodule

// File: rtl/ser_step_sat.sv
module ser_step_sat #(
  parameter int W        = 6,
  parameter int OUT_W    = 6,
  parameter int MAX      = 40,
  parameter bit MASK_TOP = 1'b0
) (
  input  logic [W-1:0]     val_i,
  output logic [OUT_W-1:0] step_o
);
  logic [W-1:0] masked;
  if (MASK_TOP) begin : g_mask
    assign masked = {1'b0, val_i[W-2:0]};
  end else begin : g_full
    assign masked = val_i;
  end
  assign step_o = (masked > W'(MAX)) ? OUT_W'(MAX) : OUT_W'(masked);
endmodule

// File: rtl/ser_setting_bank.sv
module ser_setting_bank
  import ser_ctrl_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [FUNC_W-1:0]          func_i,
  input  logic [VAL_W-1:0]           val_i,
  output logic [N_FADER*VAL_W-1:0]   fader_o,
  output logic [VAL_W-1:0]           volume_o,
  output logic [VAL_W-1:0]           treble_o,
  output logic [VAL_W-1:0]           bass_o,
  output logic [VAL_W-1:0]           insel_o
);
  for (genvar i = 0; i < N_FADER; i++) begin : g_fader
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fader_o[i*VAL_W +: VAL_W] <= '0;
      else if (commit_i && func_i == {1'b1, 2'(i)})
        fader_o[i*VAL_W +: VAL_W] <= val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      volume_o <= '0;
      treble_o <= TONE_FLAT;
      bass_o   <= TONE_FLAT;
      insel_o  <= '0;
    end else if (commit_i) begin
      case (func_i)
        FN_VOLUME: volume_o <= val_i;
        FN_TREBLE: treble_o <= val_i;
        FN_BASS:   bass_o   <= val_i;
        FN_INSEL:  insel_o  <= val_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ser_ctrl_rx.sv
module ser_ctrl_rx
  import ser_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sdata_i,
  input  logic        sclk_i,
  input  logic        sen_ni,
  output logic [23:0] fader_val_o,
  output logic [5:0]  volume_o,
  output logic [5:0]  treble_o,
  output logic [5:0]  bass_o,
  output logic [5:0]  input_sel_o,
  output logic        input_open_o,
  output logic [5:0]  vol_step_o,
  output logic [19:0] fader_step_o
);
  logic [2:0]        sync_q;
  logic              commit, addr_ok, en_fall;
  logic [FUNC_W-1:0] func;
  logic [VAL_W-1:0]  val;

  ser_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
    .clk_i, .rst_ni,
    .d_i({sen_ni, sclk_i, sdata_i}),
    .q_o(sync_q)
  );

  ser_frame_rx i_frame (
    .clk_i, .rst_ni,
    .dat_i(sync_q[0]), .sclk_i(sync_q[1]), .en_ni(sync_q[2]),
    .commit_o(commit), .addr_ok_o(addr_ok), .en_fall_o(en_fall),
    .func_o(func), .val_o(val)
  );

  ser_setting_bank i_bank (
    .clk_i, .rst_ni,
    .commit_i(commit), .func_i(func), .val_i(val),
    .fader_o(fader_val_o), .volume_o, .treble_o, .bass_o,
    .insel_o(input_sel_o)
  );

  ser_step_sat #(.W(VAL_W), .OUT_W(VSTEP_W), .MAX(VOL_MAX), .MASK_TOP(1'b0)) i_vsat (
    .val_i(volume_o), .step_o(vol_step_o)
  );

  for (genvar i = 0; i < N_FADER; i++) begin : g_fsat
    ser_step_sat #(.W(VAL_W), .OUT_W(FSTEP_W), .MAX(FADER_MAX), .MASK_TOP(1'b1)) i_fsat (
      .val_i(fader_val_o[i*VAL_W +: VAL_W]),
      .step_o(fader_step_o[i*FSTEP_W +: FSTEP_W])
    );
  end

  assign input_open_o = (input_sel_o[3:0] == 4'b0000) || (input_sel_o[3:1] == 3'b011);
endmodule

// File: rtl/ser_ctrl_rx_chk.sv
module ser_ctrl_rx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        commit_i,
  input logic        addr_ok_i,
  input logic        en_fall_i,
  input logic [47:0] settings_i,
  input logic [5:0]  vol_step_i,
  input logic [19:0] fader_step_i
);
  // R4
  setting_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(settings_i) |-> $past(commit_i));

  // R2
  commit_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> addr_ok_i);

  // R5
  addr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_fall_i |=> !addr_ok_i);

  // R7
  vol_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vol_step_i <= 6'd40);

  // R8
  fader_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fader_step_i[4:0] <= 5'd20 && fader_step_i[9:5] <= 5'd20 &&
    fader_step_i[14:10] <= 5'd20 && fader_step_i[19:15] <= 5'd20);
endmodule

bind ser_ctrl_rx ser_ctrl_rx_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .commit_i(commit), .addr_ok_i(addr_ok), .en_fall_i(en_fall),
  .settings_i({fader_val_o, volume_o, treble_o, bass_o, input_sel_o}),
  .vol_step_i(vol_step_o), .fader_step_i(fader_step_o)
);

// File: tb/test_ser_ctrl_rx.sv
module test_ser_ctrl_rx;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, sen_n = 1'b1;
  logic [23:0] fader_val;
  logic [5:0]  volume, treble, bass, input_sel, vol_step;
  logic        input_open;
  logic [19:0] fader_step;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  localparam int HALF = 8;

  logic [5:0] e_fader [4];
  logic [5:0] e_vol, e_treb, e_bass, e_in;

  always #2.5 clk = ~clk;

  ser_ctrl_rx i_ser_ctrl_rx (
    .clk_i(clk), .rst_ni, .sdata_i(sdata), .sclk_i(sclk), .sen_ni(sen_n),
    .fader_val_o(fader_val), .volume_o(volume), .treble_o(treble), .bass_o(bass),
    .input_sel_o(input_sel), .input_open_o(input_open),
    .vol_step_o(vol_step), .fader_step_o(fader_step)
  );

  // {function, value}
  localparam logic [8:0] VEC [10] = '{
    {3'b011, 6'd20}, {3'b111, 6'd5}, {3'b110, 6'b110111}, {3'b101, 6'b101010},
    {3'b100, 6'd21}, {3'b011, 6'd63}, {3'b010, 6'd9}, {3'b001, 6'd3},
    {3'b000, 6'd7}, {3'b011, 6'd41}
  };

  function automatic logic [5:0] vstep(logic [5:0] v);
    return (v > 6'd40) ? 6'd40 : v;
  endfunction
  function automatic logic [4:0] fstep(logic [5:0] v);
    return (v[4:0] > 5'd20) ? 5'd20 : v[4:0];
  endfunction
  function automatic logic open_of(logic [5:0] v);
    return v[3:0] == 4'd0 || v[3:0] == 4'd6 || v[3:0] == 4'd7;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(req, "fader", 32'(fader_val[6*i +: 6]), 32'(e_fader[i]));
      chk(req, "fader_step", 32'(fader_step[5*i +: 5]), 32'(fstep(e_fader[i])));
    end
    chk(req, "volume", 32'(volume), 32'(e_vol));
    chk(req, "vol_step", 32'(vol_step), 32'(vstep(e_vol)));
    chk(req, "treble", 32'(treble), 32'(e_treb));
    chk(req, "bass", 32'(bass), 32'(e_bass));
    chk(req, "input_sel", 32'(input_sel), 32'(e_in));
    chk(req, "input_open", 32'(input_open), 32'(open_of(e_in)));
  endtask

  task automatic model(logic [2:0] f, logic [5:0] v);
    if (f[2]) e_fader[f[1:0]] = v;
    else case (f[1:0])
      2'b11: e_vol = v;
      2'b10: e_treb = v;
      2'b01: e_bass = v;
      default: e_in = v;
    endcase
  endtask

  task automatic wait_sys(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic en_low();
    @(negedge clk); sen_n = 1'b0; wait_sys(HALF);
  endtask

  task automatic en_high();
    @(negedge clk); sen_n = 1'b1; wait_sys(12);
  endtask

  task automatic send_bits(int n, logic [63:0] b);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdata = b[i]; wait_sys(HALF);
      sclk = 1'b1; wait_sys(HALF);
      sclk = 1'b0;
    end
    wait_sys(HALF);
  endtask

  task automatic frame(logic [2:0] f, logic [5:0] v);
    en_low();
    send_bits(11, 64'({2'b10, f, v}));
    en_high();
  endtask

  initial begin
    wait_sys(150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) e_fader[i] = 6'd0;
    e_vol = 6'd0; e_treb = 6'b000110; e_bass = 6'b000110; e_in = 6'd0;
    wait_sys(4);
    rst_ni = 1'b1;
    wait_sys(4);
    // R1 reset state
    check_all("R1");

    // R6 R7 R8 R11 table of frames
    for (int k = 0; k < 10; k++) begin
      frame(VEC[k][8:6], VEC[k][5:0]);
      model(VEC[k][8:6], VEC[k][5:0]);
      check_all("R6");
    end

    // R7 explicit saturation points: value 41 still at 0 dB step
    chk("R7", "vol_step@41", 32'(vol_step), 32'd40);
    frame(3'b011, 6'd40); model(3'b011, 6'd40);
    chk("R7", "vol_step@40", 32'(vol_step), 32'd40);
    frame(3'b011, 6'd39); model(3'b011, 6'd39);
    chk("R7", "vol_step@39", 32'(vol_step), 32'd39);

    // R8 fader top bit ignored: 101010 -> step 10 on left front (index 1)
    chk("R8", "lf_step", 32'(fader_step[9:5]), 32'd10);
    // R8 110111 saturates at 20 on right rear (index 2)
    chk("R8", "rr_step", 32'(fader_step[14:10]), 32'd20);

    // R11 open input codes
    frame(3'b000, 6'b010110); model(3'b000, 6'b010110);
    chk("R11", "open@x0110", 32'(input_open), 32'd1);
    frame(3'b000, 6'd5); model(3'b000, 6'd5);
    chk("R11", "open@0101", 32'(input_open), 32'd0);
    frame(3'b000, 6'b100000); model(3'b000, 6'b100000);
    chk("R11", "open@0000", 32'(input_open), 32'd1);

    // R2 wrong address 11 and 01
    en_low(); send_bits(11, 64'({2'b11, 3'b011, 6'd1})); en_high();
    en_low(); send_bits(11, 64'({2'b01, 3'b011, 6'd2})); en_high();
    check_all("R2");

    // R3 over-long stream, last nine bits used
    en_low(); send_bits(16, 64'({2'b10, 5'b11111, 3'b011, 6'd20})); en_high();
    model(3'b011, 6'd20);
    check_all("R3");

    // R10 short payload commits nothing
    en_low(); send_bits(8, 64'({2'b10, 3'b011, 3'b000})); en_high();
    check_all("R10");

    // R4 nothing changes until enable rises
    en_low(); send_bits(11, 64'({2'b10, 3'b011, 6'd33}));
    wait_sys(16);
    check_all("R4");
    en_high(); model(3'b011, 6'd33);
    check_all("R4");

    // R5 mid-frame enable glitch clears address; then bad address must be ignored
    en_low(); send_bits(4, 64'(4'b1001));
    @(negedge clk); sen_n = 1'b1; wait_sys(4);
    sen_n = 1'b0; wait_sys(HALF);
    send_bits(11, 64'({2'b01, 3'b011, 6'd2}));
    en_high();
    check_all("R5");

    // R5 enable falling while serial clock high voids the frame
    @(negedge clk); sclk = 1'b1; wait_sys(HALF);
    sen_n = 1'b0; wait_sys(HALF);
    sclk = 1'b0; wait_sys(HALF);
    send_bits(11, 64'({2'b10, 3'b011, 6'd3}));
    en_high();
    check_all("R5");

    // R9 clocking while enable high has no effect
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); sdata = i[0]; wait_sys(HALF);
      sclk = 1'b1; wait_sys(HALF); sclk = 1'b0;
    end
    wait_sys(12);
    check_all("R9");

    // R9 recovery: normal frame still works
    frame(3'b100, 6'd11); model(3'b100, 6'd11);
    check_all("R9");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule